// File: doc/BRIEF.md
# Spread-Spectrum PWM Oscillator

This block sets the switching rhythm of a fixed-frequency, current-mode PWM controller. It divides a system clock into switching cycles and marks the first clock of each cycle with a one-clock start pulse. It also drives a gate-enable window that opens at that start. Two nominal rates are built in: a low one near 60 kHz and a high one near 115 kHz. A pin selects which one is used. To spread harmonic energy, the cycle length is swept up and down in a slow triangle, by about ±4 kHz for the low rate and ±8 kHz for the high rate, with a full sweep roughly 230 times a second.

Inside each cycle, the gate closes at whichever of two events comes first: an external current-comparator flag or a duty ceiling of 80 % of the current period. A blanking window keeps the gate open for a minimum on-time whatever the comparator says. A stop request forces the gate low. The counters keep running during a stop, so the cycle timing is unbroken when the gate resumes. All counts are integer results of parameters that give the clock and target frequencies.

Top module: `ssc_pwm_osc`

## Requirements
- R1: The nominal period in clocks is floor(CLK_HZ / nominal Hz). While reset is held, both outputs are low. The first cycle after reset lasts exactly the nominal period, carries no start pulse, and keeps the gate low.
- R2: Each period stays within the sweep limits. The shortest is floor(CLK_HZ / (nominal + deviation)) and the longest is floor(CLK_HZ / (nominal − deviation)). Over a full sweep both limits are reached.
- R3: The sweep begins at the nominal period and moves upward first. It holds each period for DWELL cycles and then moves it by STEP. A move that would reach or pass a limit is clamped to that limit and reverses the direction. The half-sweep count is H = max(1, nominal Hz / (2·SWEEP_HZ)). With span = longest − shortest, STEP = max(1, span / H) and DWELL = max(1, H·STEP / span). The first cycle after reset counts toward the first DWELL.
- R4: `cycleStart` is high for exactly the first clock of every cycle after the first. The gate opens in that same clock unless a stop was seen on the clock edge that began the cycle.
- R5: The gate is open for at most floor(period · DUTY_PCT / 100) clocks of a cycle.
- R6: A trip flag that is sampled high on a clock edge after the blanking window closes the gate from the next clock.
- R7: The blanking length is MIN_ON = max(1, ceil(MIN_ON_NS · CLK_HZ / 1e9)) clocks. A trip flag during the first MIN_ON−1 clocks of a cycle has no effect, so a tripped cycle keeps the gate open for max(trip clock + 1, MIN_ON) clocks.
- R8: A stop request sampled high closes the gate from the next clock, even inside the blanking window. The gate then stays closed until a cycle begins on an edge where the stop request is low. Cycle lengths are not affected by a stop.
- R9: `hiVariant` = 1 selects the high-rate parameter set and 0 selects the low-rate set. The input must be held stable while reset is released, and changed only under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hiVariant | input | 1 | 1 selects the high nominal rate, 0 the low one |
| currentTrip | input | 1 | Current-comparator flag requesting gate turn-off |
| stopReq | input | 1 | Forces the gate low while high |
| cycleStart | output | 1 | One-clock pulse on the first clock of each cycle |
| gateOn | output | 1 | Gate-enable window |

## Verification
A cycle boundary is registered once, so `cycleStart` and the gate's rising edge both appear in the first clock of the new cycle. A trip or stop sampled on one edge shows on `gateOn` one clock later. The bench drives trip and stop at falling edges, using a position counter that restarts on each observed start pulse, and samples at falling edges only. It measures every cycle whole: the clocks between start pulses and the clocks with the gate open. It compares these against per-cycle expectations from a period model and the R5 to R8 rules, so each result is judged at the edge where it must already be settled.

// File: rtl/ssc_osc_pkg.sv
package ssc_osc_pkg;

  // timing flags the timebase hands to the gate control every clock
  typedef struct packed {
    logic wrap;      // last clock of the current cycle
    logic tripOpen;  // blanking window is over
    logic dutyEnd;   // next clock would reach the duty ceiling
  } tickFlags_t;

  function automatic int countOf(longint clkHz, longint hz);
    return int'(clkHz / hz);
  endfunction

  function automatic int halfOf(int nomHz, int sweepHz);
    int h;
    h = nomHz / (2 * sweepHz);
    return (h < 1) ? 1 : h;
  endfunction

  function automatic int stepOf(int span, int half);
    int s;
    s = span / half;
    return (s < 1) ? 1 : s;
  endfunction

  function automatic int dwellOf(int span, int half, int step);
    int d;
    d = (span < 1) ? 1 : (half * step) / span;
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int minOnOf(longint clkHz, longint ns);
    longint c;
    c = (ns * clkHz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/pwmosc_timebase.sv
module pwmosc_timebase
  import ssc_osc_pkg::*;
#(
  parameter int PW       = 7,
  parameter int LO_NOM   = 66,
  parameter int LO_MIN   = 62,
  parameter int LO_MAX   = 71,
  parameter int LO_STEP  = 1,
  parameter int LO_DWELL = 14,
  parameter int HI_NOM   = 34,
  parameter int HI_MIN   = 32,
  parameter int HI_MAX   = 37,
  parameter int HI_STEP  = 1,
  parameter int HI_DWELL = 50,
  parameter int DUTY_PCT = 80,
  parameter int MIN_ON   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hiVariant,
  output tickFlags_t flags
);

  localparam int MAX_DWELL = (LO_DWELL > HI_DWELL) ? LO_DWELL : HI_DWELL;
  localparam int DW = (MAX_DWELL < 2) ? 1 : $clog2(MAX_DWELL + 1);
  localparam int MW = PW + 7;

  typedef logic signed [PW:0] off_t;

  localparam off_t LO_UP = off_t'(LO_MAX - LO_NOM);
  localparam off_t LO_DN = off_t'(LO_NOM - LO_MIN);
  localparam off_t HI_UP = off_t'(HI_MAX - HI_NOM);
  localparam off_t HI_DN = off_t'(HI_NOM - HI_MIN);

  logic [PW-1:0] cnt, period, nomSel, minSel, maxSel;
  logic [DW-1:0] dwell, dwellLast;
  off_t          offset, offNext, upLim, dnLim, stepS;
  logic          goingUp, upNext, wrap;
  logic [MW-1:0] dutyLim;

  // variant selection
  always_comb begin
    if (hiVariant) begin
      nomSel    = PW'(HI_NOM);
      minSel    = PW'(HI_MIN);
      maxSel    = PW'(HI_MAX);
      upLim     = HI_UP;
      dnLim     = HI_DN;
      stepS     = off_t'(HI_STEP);
      dwellLast = DW'(HI_DWELL - 1);
    end else begin
      nomSel    = PW'(LO_NOM);
      minSel    = PW'(LO_MIN);
      maxSel    = PW'(LO_MAX);
      upLim     = LO_UP;
      dnLim     = LO_DN;
      stepS     = off_t'(LO_STEP);
      dwellLast = DW'(LO_DWELL - 1);
    end
  end

  // period is nominal plus a signed sweep offset, so reset needs no input
  assign period = nomSel + PW'(offset);
  assign wrap   = (cnt == period - PW'(1));

  // triangle step with clamp and reversal
  always_comb begin
    offNext = offset;
    upNext  = goingUp;
    if (goingUp) begin
      if (offset + stepS >= upLim) begin
        offNext = upLim;
        upNext  = 1'b0;
      end else begin
        offNext = offset + stepS;
      end
    end else begin
      if (offset - stepS <= -dnLim) begin
        offNext = -dnLim;
        upNext  = 1'b1;
      end else begin
        offNext = offset - stepS;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      offset  <= '0;
      goingUp <= 1'b1;
      dwell   <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + PW'(1);
      if (wrap) begin
        if (dwell == dwellLast) begin
          dwell   <= '0;
          offset  <= offNext;
          goingUp <= upNext;
        end else begin
          dwell <= dwell + DW'(1);
        end
      end
    end
  end

  assign dutyLim        = (MW'(period) * MW'(DUTY_PCT)) / MW'(100);
  assign flags.wrap     = wrap;
  assign flags.tripOpen = (cnt >= PW'(MIN_ON - 1));
  assign flags.dutyEnd  = ((MW'(cnt) + MW'(1)) >= dutyLim);

  assert_cnt_below_period_R1: assert property (@(posedge clk) disable iff (!rstN)
    cnt < period);

  assert_period_in_band_R2: assert property (@(posedge clk) disable iff (!rstN)
    (period >= minSel) && (period <= maxSel));

  assert_period_only_at_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrap) |-> $stable(period));

  assert_variant_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    $stable(hiVariant));

endmodule

// File: rtl/pwmosc_gatectl.sv
module pwmosc_gatectl
  import ssc_osc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tickFlags_t flags,
  input  logic       currentTrip,
  input  logic       stopReq,
  output logic       cycleStart,
  output logic       gateOn
);

  logic gateQ, startQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= flags.wrap;
      if (stopReq) begin
        gateQ <= 1'b0;
      end else if (flags.wrap) begin
        gateQ <= 1'b1;
      end else if (gateQ && (flags.dutyEnd || (currentTrip && flags.tripOpen))) begin
        gateQ <= 1'b0;
      end
    end
  end

  assign cycleStart = startQ;
  assign gateOn     = gateQ;

  assert_stop_forces_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopReq) |-> !gateOn);

  assert_gate_rises_at_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> cycleStart);

  assert_start_opens_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && !$past(stopReq)) |-> gateOn);

  assert_min_on_respected_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateOn) && !$past(stopReq)) |-> $past(flags.tripOpen));

endmodule

// File: rtl/ssc_pwm_osc.sv
module ssc_pwm_osc
  import ssc_osc_pkg::*;
#(
  parameter int CLK_HZ    = 4_000_000,
  parameter int LO_NOM_HZ = 60_000,
  parameter int LO_DEV_HZ = 4_000,
  parameter int HI_NOM_HZ = 115_000,
  parameter int HI_DEV_HZ = 8_000,
  parameter int SWEEP_HZ  = 230,
  parameter int DUTY_PCT  = 80,
  parameter int MIN_ON_NS = 450
) (
  input  logic clk,
  input  logic rstN,
  input  logic hiVariant,
  input  logic currentTrip,
  input  logic stopReq,
  output logic cycleStart,
  output logic gateOn
);

  localparam longint CLK_L = longint'(CLK_HZ);

  localparam int LO_NOM   = countOf(CLK_L, longint'(LO_NOM_HZ));
  localparam int LO_MIN   = countOf(CLK_L, longint'(LO_NOM_HZ + LO_DEV_HZ));
  localparam int LO_MAX   = countOf(CLK_L, longint'(LO_NOM_HZ - LO_DEV_HZ));
  localparam int LO_HALF  = halfOf(LO_NOM_HZ, SWEEP_HZ);
  localparam int LO_STEP  = stepOf(LO_MAX - LO_MIN, LO_HALF);
  localparam int LO_DWELL = dwellOf(LO_MAX - LO_MIN, LO_HALF, LO_STEP);

  localparam int HI_NOM   = countOf(CLK_L, longint'(HI_NOM_HZ));
  localparam int HI_MIN   = countOf(CLK_L, longint'(HI_NOM_HZ + HI_DEV_HZ));
  localparam int HI_MAX   = countOf(CLK_L, longint'(HI_NOM_HZ - HI_DEV_HZ));
  localparam int HI_HALF  = halfOf(HI_NOM_HZ, SWEEP_HZ);
  localparam int HI_STEP  = stepOf(HI_MAX - HI_MIN, HI_HALF);
  localparam int HI_DWELL = dwellOf(HI_MAX - HI_MIN, HI_HALF, HI_STEP);

  localparam int MIN_ON   = minOnOf(CLK_L, longint'(MIN_ON_NS));
  localparam int TOP_MAX  = (LO_MAX > HI_MAX) ? LO_MAX : HI_MAX;
  localparam int PW       = $clog2(TOP_MAX + 1);

  tickFlags_t flags;

  pwmosc_timebase #(
    .PW(PW),
    .LO_NOM(LO_NOM), .LO_MIN(LO_MIN), .LO_MAX(LO_MAX),
    .LO_STEP(LO_STEP), .LO_DWELL(LO_DWELL),
    .HI_NOM(HI_NOM), .HI_MIN(HI_MIN), .HI_MAX(HI_MAX),
    .HI_STEP(HI_STEP), .HI_DWELL(HI_DWELL),
    .DUTY_PCT(DUTY_PCT), .MIN_ON(MIN_ON)
  ) u_timebase (
    .clk       (clk),
    .rstN      (rstN),
    .hiVariant (hiVariant),
    .flags     (flags)
  );

  pwmosc_gatectl u_gatectl (
    .clk         (clk),
    .rstN        (rstN),
    .flags       (flags),
    .currentTrip (currentTrip),
    .stopReq     (stopReq),
    .cycleStart  (cycleStart),
    .gateOn      (gateOn)
  );

endmodule

// File: tb/ssc_pwm_osc_tb.sv
module ssc_pwm_osc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int DUTY       = 80;
  localparam int MIN_ON     = 4;      // ceil(1000 ns * 4 MHz)
  localparam int WATCHDOG   = 150_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hiVariant = 1'b0;
  logic currentTrip = 1'b0;
  logic stopReq = 1'b0;
  logic cycleStart, gateOn;

  ssc_pwm_osc #(.CLK_HZ(CLK_HZ), .MIN_ON_NS(1000)) u_dut (
    .clk(clk), .rstN(rstN), .hiVariant(hiVariant),
    .currentTrip(currentTrip), .stopReq(stopReq),
    .cycleStart(cycleStart), .gateOn(gateOn)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int    period;
    int    onLen;
    string pTag;
    string oTag;
  } exp_t;

  exp_t q[$];
  int   nChecks = 0;
  int   nFail = 0;
  int   minSeen, maxSeen;
  int   mNom, mMin, mMax, mStep, mDwellLen, mPer, mDw;
  bit   mUp, lastStop;
  string perTag;

  task automatic checkEq(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // ---------- period model built from the sweep rules ----------
  task automatic modelInit(bit hi);
    int nomHz, devHz, half, span;
    nomHz = hi ? 115_000 : 60_000;
    devHz = hi ? 8_000 : 4_000;
    mNom = CLK_HZ / nomHz;
    mMin = CLK_HZ / (nomHz + devHz);
    mMax = CLK_HZ / (nomHz - devHz);
    half = nomHz / (2 * 230);
    if (half < 1) half = 1;
    span = mMax - mMin;
    mStep = span / half;
    if (mStep < 1) mStep = 1;
    mDwellLen = (span < 1) ? 1 : (half * mStep) / span;
    if (mDwellLen < 1) mDwellLen = 1;
    mPer = mNom; mUp = 1'b1; mDw = 0;
  endtask

  task automatic modelAdvance();
    if (mDw == mDwellLen - 1) begin
      mDw = 0;
      if (mUp) begin
        if (mPer + mStep >= mMax) begin mPer = mMax; mUp = 1'b0; end
        else mPer = mPer + mStep;
      end else begin
        if (mPer - mStep <= mMin) begin mPer = mMin; mUp = 1'b1; end
        else mPer = mPer - mStep;
      end
    end else begin
      mDw++;
    end
  endtask

  // ---------- driver: called at the falling edge that shows a start pulse ----------
  task automatic driveCycle(int tripAt, bit stopLvl);
    exp_t e;
    int dl, pos;
    dl = (mPer * DUTY) / 100;
    e.period = mPer;
    e.pTag = perTag;
    if (lastStop) begin
      e.onLen = 0; e.oTag = "R8";
    end else if (stopLvl) begin
      e.onLen = 1; e.oTag = "R8";
    end else if (tripAt < 0) begin
      e.onLen = dl; e.oTag = "R5";
    end else begin
      e.onLen = (tripAt + 1 > MIN_ON) ? tripAt + 1 : MIN_ON;
      if (e.onLen > dl) begin e.onLen = dl; e.oTag = "R5"; end
      else e.oTag = (tripAt + 1 < MIN_ON) ? "R7" : "R6";
    end
    // R4: gate opens together with the start pulse unless stopped on the edge before
    checkEq("R4", "gate at cycle start", int'(gateOn), lastStop ? 0 : 1);
    q.push_back(e);
    lastStop = stopLvl;
    stopReq = stopLvl;
    modelAdvance();
    pos = 0;
    currentTrip = (tripAt == 0);
    forever begin
      @(negedge clk);
      if (cycleStart) break;
      pos++;
      currentTrip = (tripAt >= 0) && (pos >= tripAt);
    end
  endtask

  task automatic startPhase(bit hi);
    rstN = 1'b0;
    hiVariant = hi;
    stopReq = 1'b0;
    currentTrip = 1'b0;
    lastStop = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    // R1: outputs held low under reset
    checkEq("R1", "cycleStart in reset", int'(cycleStart), 0);
    checkEq("R1", "gateOn in reset", int'(gateOn), 0);
    modelInit(hi);
    minSeen = 1_000_000;
    maxSeen = 0;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    rstN = 1'b1;
    begin
      exp_t w;
      w.period = mNom; w.onLen = 0; w.pTag = "R1"; w.oTag = "R1";
      q.push_back(w);
    end
    modelAdvance();
    do @(negedge clk); while (!cycleStart);
  endtask

  task automatic endPhase(string tag);
    currentTrip = 1'b0;
    stopReq = 1'b0;
    @(posedge clk);
    checkEq(tag, "expected cycles left over", q.size(), 0);
    checkEq("R2", "shortest period seen", minSeen, mMin);
  endtask

  // ---------- monitor ----------
  bit measuring = 1'b0;
  int len, onCnt;
  always @(negedge clk) begin
    if (!rstN) begin
      measuring = 1'b0;
    end else if (!measuring) begin
      measuring = 1'b1;
      len = 1;
      onCnt = gateOn ? 1 : 0;
    end else if (cycleStart) begin
      if (q.size() == 0) begin
        nChecks++;
        nFail++;
        $display("FAIL R4 unexpected cycle start actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        checkEq(e.pTag, "cycle length", len, e.period);
        checkEq(e.oTag, "gate open clocks", onCnt, e.onLen);
        if (e.pTag != "R1") begin
          if (len < minSeen) minSeen = len;
          if (len > maxSeen) maxSeen = len;
        end
      end
      len = 1;
      onCnt = gateOn ? 1 : 0;
    end else begin
      len++;
      if (gateOn) onCnt++;
    end
  end

  // ---------- watchdog ----------
  int clkCount = 0;
  always @(negedge clk) begin
    clkCount++;
    if (clkCount > WATCHDOG) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", clkCount, WATCHDOG);
      finishRun();
    end
  end

  // ---------- stimulus ----------
  initial begin
    int trips[7];
    trips = '{1, 2, 3, 4, 10, 30, 60};

    // low variant: full sweep with both reversals (R2, R3)
    perTag = "R3";
    startPhase(1'b0);
    for (int i = 1; i <= 240; i++) begin
      if (i >= 21 && i <= 27) driveCycle(trips[i - 21], 1'b0);   // R6, R7, R5
      else if (i >= 28 && i <= 30) driveCycle(-1, 1'b1);          // R8 stop held
      else if (i == 31) driveCycle(-1, 1'b0);                     // R8 release
      else if (i % 11 == 0) driveCycle(0, 1'b0);                  // R7 trip inside blanking
      else if (i % 7 == 0) driveCycle(5, 1'b0);                   // R6
      else driveCycle(-1, 1'b0);                                  // R5
    end
    endPhase("R3");
    checkEq("R2", "longest period seen", maxSeen, mMax);

    // high variant (R9)
    perTag = "R9";
    startPhase(1'b1);
    for (int i = 1; i <= 220; i++) begin
      if (i >= 100 && i <= 102) driveCycle(-1, 1'b1);             // R8
      else if (i == 103) driveCycle(-1, 1'b0);
      else if (i % 9 == 0) driveCycle(12, 1'b0);                  // R6
      else if (i % 6 == 0) driveCycle(2, 1'b0);                   // R7
      else if (i % 13 == 0) driveCycle(30, 1'b0);                 // R5 clip
      else driveCycle(-1, 1'b0);
    end
    currentTrip = 1'b0;
    stopReq = 1'b0;
    @(posedge clk);
    checkEq("R9", "expected cycles left over", q.size(), 0);
    checkEq("R9", "longest high-rate period seen", maxSeen, mMax);

    finishRun();
  end

endmodule